// File: doc/BRIEF.md
# DMA Linked-List Transfer Engine

This block moves data for one DMA channel at a time. An external scheduler grants a channel, and the engine then moves one element through a request/ready memory master port. To do that it reads one or more source pieces into a small staging buffer and writes the buffer out in destination-sized pieces. It then updates the channel's addresses and its remaining count. The engine holds a register set for each channel: source address, destination address, next-descriptor pointer, control word and configuration word. A simple write port loads these registers, and a registered read port returns them.

When a channel's count runs out, the engine checks the next-descriptor pointer. If the pointer is nonzero, the engine fetches a four-word descriptor from memory at that pointer and reloads the channel, so a chain of transfers proceeds without software help. If the pointer is zero, the engine switches the channel off. When enabled by the control word, a terminal-count event is raised for the channel. A memory error stops the channel and raises an error event. Every grant ends with a one-cycle done pulse back to the scheduler.

Top module: `lli_xfer_engine`

## Requirements
- R1: After a synchronous reset, every channel register reads zero, no channel is enabled, and mem_req, done and busy are low.
- R2: A write with cfg_we stores cfg_wdata into the register chosen by cfg_sel (0 source, 1 destination, 2 pointer, 3 control, 4 configuration) of channel cfg_ch. A read with rd_en returns the chosen register on rd_data one cycle later.
- R3: A grant to a channel with configuration bit 0 clear, or with a zero count in control bits 11:0, produces a done pulse and no memory request, and it leaves the channel registers unchanged.
- R4: Source width is 1<<c bytes for c = control bits 20:18, and destination width is taken the same way from bits 23:21; a code above 2 acts as 2 (a word). Each element reads max/source-width pieces and then writes max/destination-width pieces. mem_size carries the width code, data is right-aligned, and the first read fills the lowest bytes of the buffer, which the first write takes.
- R5: With control bit 26 set, the source address advances by the source width after each read. With control bit 27 set, the destination address advances by the destination width after each write. Otherwise that address stays fixed.
- R6: Each completed element lowers control bits 11:0 by one and keeps bits 31:12.
- R7: When the count reaches zero with a zero pointer, configuration bit 0 is cleared and the other configuration bits are kept.
- R8: When the count reaches zero with a nonzero pointer P, word reads at P, P+4, P+12 and P+8, in that order, load source, destination, control and then the new pointer. The channel stays enabled.
- R9: At terminal count, tc_evt for the channel pulses together with done if bit 31 of the control word is set, using the reloaded word when a reload took place.
- R10: A memory response with mem_err set pulses err_evt for the channel with done, clears its configuration bit 0, and leaves the count unchanged.
- R11: mem_req, once raised, holds its address, direction, size and write data until mem_ready. done is a single-cycle pulse per accepted grant. A grant arriving while busy is ignored.
- R12: ch_en changes only after a cfg_we write or after a done pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Channel register write strobe |
| cfg_ch | input | CHW | Channel for the write |
| cfg_sel | input | 3 | Register select for the write |
| cfg_wdata | input | 32 | Write data |
| rd_en | input | 1 | Register read strobe |
| rd_ch | input | CHW | Channel for the read |
| rd_sel | input | 3 | Register select for the read |
| rd_data | output | 32 | Read data, one cycle after rd_en |
| grant_valid | input | 1 | Scheduler grant |
| grant_ch | input | CHW | Granted channel |
| busy | output | 1 | Engine working on a grant |
| done | output | 1 | One-cycle pulse at the end of a grant |
| done_ch | output | CHW | Channel the done pulse belongs to |
| tc_evt | output | NCH | Terminal-count event pulses, one bit per channel |
| err_evt | output | NCH | Error event pulses, one bit per channel |
| ch_en | output | NCH | Configuration bit 0 of each channel |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Request is a write |
| mem_size | output | 2 | Access size code (0 byte, 1 half, 2 word) |
| mem_addr | output | 32 | Byte address |
| mem_wdata | output | 32 | Right-aligned write data |
| mem_ready | input | 1 | Memory completes the request |
| mem_err | input | 1 | Error response, valid with mem_ready |
| mem_rdata | input | 32 | Right-aligned read data |

## Verification
The hardest case to reach from the ports is terminal count followed by a descriptor reload. In that case the terminal-count event depends on bit 31 of the newly fetched control word, not on the word that was running. The bench builds a one-element channel whose own control word has bit 31 clear and whose descriptor in memory has it set. It then checks that the event fires, and it checks the exact order of the descriptor fetch addresses in the memory model's transaction log. Error responses are reached by marking one source address in the memory model as faulting.

// File: rtl/lli_pkg.sv
package lli_pkg;
  localparam int WORD_W   = 32;
  localparam int CNT_W    = 12;
  localparam int SWC_LSB  = 18;
  localparam int DWC_LSB  = 21;
  localparam int SINC_BIT = 26;
  localparam int DINC_BIT = 27;
  localparam int TCIE_BIT = 31;
  localparam int EN_BIT   = 0;

  typedef struct packed {
    logic [WORD_W-1:0] src;
    logic [WORD_W-1:0] dst;
    logic [WORD_W-1:0] ptr;
    logic [WORD_W-1:0] ctrl;
    logic [WORD_W-1:0] conf;
  } chan_regs_t;

  typedef enum logic [2:0] {
    ST_IDLE, ST_RD, ST_WSET, ST_WR, ST_DESC, ST_FIN
  } eng_state_t;

  function automatic logic [1:0] width_code(input logic [2:0] f);
    return (f > 3'd2) ? 2'd2 : f[1:0];
  endfunction

  function automatic logic [WORD_W-1:0] width_mask(input logic [1:0] wc);
    case (wc)
      2'd0:    return 32'h0000_00FF;
      2'd1:    return 32'h0000_FFFF;
      default: return 32'hFFFF_FFFF;
    endcase
  endfunction

  // descriptor fetch order: source, destination, control, next pointer
  function automatic logic [WORD_W-1:0] desc_off(input logic [1:0] idx);
    case (idx)
      2'd0:    return 32'd0;
      2'd1:    return 32'd4;
      2'd2:    return 32'd12;
      default: return 32'd8;
    endcase
  endfunction
endpackage

// File: rtl/lli_chan_regs.sv
module lli_chan_regs
  import lli_pkg::*;
#(
  parameter int NCH = 8,
  localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [CHW-1:0]    cfg_ch,
  input  logic [2:0]        cfg_sel,
  input  logic [WORD_W-1:0] cfg_wdata,
  input  logic              rd_en,
  input  logic [CHW-1:0]    rd_ch,
  input  logic [2:0]        rd_sel,
  output logic [WORD_W-1:0] rd_data,
  input  logic [CHW-1:0]    look_ch,
  output chan_regs_t        look,
  input  logic              wb_en,
  input  logic [CHW-1:0]    wb_ch,
  input  chan_regs_t        wb_val,
  output logic [NCH-1:0]    ch_en
);
  chan_regs_t regs_q [NCH];

  for (genvar i = 0; i < NCH; i++) begin : g_chan
    always_ff @(posedge clk) begin
      if (rst) begin
        regs_q[i] <= '0;
      end else if (wb_en && (int'(wb_ch) == i)) begin
        regs_q[i] <= wb_val;
      end else if (cfg_we && (int'(cfg_ch) == i)) begin
        case (cfg_sel)
          3'd0: regs_q[i].src  <= cfg_wdata;
          3'd1: regs_q[i].dst  <= cfg_wdata;
          3'd2: regs_q[i].ptr  <= cfg_wdata;
          3'd3: regs_q[i].ctrl <= cfg_wdata;
          3'd4: regs_q[i].conf <= cfg_wdata;
          default: ;
        endcase
      end
    end
    assign ch_en[i] = regs_q[i].conf[EN_BIT];
  end

  always_comb begin
    look = '0;
    if (int'(look_ch) < NCH) look = regs_q[look_ch];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= '0;
    end else if (rd_en) begin
      rd_data <= '0;
      if (int'(rd_ch) < NCH) begin
        case (rd_sel)
          3'd0: rd_data <= regs_q[rd_ch].src;
          3'd1: rd_data <= regs_q[rd_ch].dst;
          3'd2: rd_data <= regs_q[rd_ch].ptr;
          3'd3: rd_data <= regs_q[rd_ch].ctrl;
          3'd4: rd_data <= regs_q[rd_ch].conf;
          default: rd_data <= '0;
        endcase
      end
    end
  end
endmodule

// File: rtl/lli_pack.sv
module lli_pack
  import lli_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              ld,
  input  logic [1:0]        ld_idx,
  input  logic [1:0]        ld_wc,
  input  logic [WORD_W-1:0] ld_data,
  input  logic [1:0]        pc_idx,
  input  logic [1:0]        pc_wc,
  output logic [WORD_W-1:0] piece
);
  logic [WORD_W-1:0] buf_q;
  logic [1:0]        ld_byte;
  logic [1:0]        pc_byte;
  logic [4:0]        ld_sh;
  logic [4:0]        pc_sh;
  logic [WORD_W-1:0] ld_m;

  assign ld_byte = 2'(ld_idx << ld_wc);
  assign pc_byte = 2'(pc_idx << pc_wc);
  assign ld_sh   = {ld_byte, 3'b000};
  assign pc_sh   = {pc_byte, 3'b000};
  assign ld_m    = width_mask(ld_wc);

  always_ff @(posedge clk) begin
    if (rst) buf_q <= '0;
    else if (ld) buf_q <= (buf_q & ~(ld_m << ld_sh)) | ((ld_data & ld_m) << ld_sh);
  end

  assign piece = (buf_q >> pc_sh) & width_mask(pc_wc);
endmodule

// File: rtl/lli_engine_fsm.sv
module lli_engine_fsm
  import lli_pkg::*;
#(
  parameter int NCH = 8,
  localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              grant_valid,
  input  logic [CHW-1:0]    grant_ch,
  output logic [CHW-1:0]    look_ch,
  input  chan_regs_t        look,
  output logic              wb_en,
  output logic [CHW-1:0]    wb_ch,
  output chan_regs_t        wb_val,
  output logic              pk_ld,
  output logic [1:0]        pk_ld_idx,
  output logic [1:0]        pk_ld_wc,
  output logic [1:0]        pk_pc_idx,
  output logic [1:0]        pk_pc_wc,
  input  logic [WORD_W-1:0] piece,
  output logic              busy,
  output logic              done,
  output logic [CHW-1:0]    done_ch,
  output logic [NCH-1:0]    tc_evt,
  output logic [NCH-1:0]    err_evt,
  output logic              mem_req,
  output logic              mem_we,
  output logic [1:0]        mem_size,
  output logic [WORD_W-1:0] mem_addr,
  output logic [WORD_W-1:0] mem_wdata,
  input  logic              mem_ready,
  input  logic              mem_err,
  input  logic [WORD_W-1:0] mem_rdata
);
  eng_state_t        state;
  chan_regs_t        w;
  logic [CHW-1:0]    w_ch;
  logic [1:0]        rd_idx, wr_idx, d_idx;
  logic [1:0]        swc, dwc, xc;
  logic [2:0]        n_rd, n_wr;
  logic              rd_last, wr_last;
  logic [WORD_W-1:0] src_n, dst_n, ctrl_n;
  logic [CNT_W-1:0]  cnt_n;

  assign swc     = width_code(w.ctrl[SWC_LSB +: 3]);
  assign dwc     = width_code(w.ctrl[DWC_LSB +: 3]);
  assign xc      = (swc > dwc) ? swc : dwc;
  assign n_rd    = 3'd1 << (xc - swc);
  assign n_wr    = 3'd1 << (xc - dwc);
  assign rd_last = ({1'b0, rd_idx} == n_rd - 3'd1);
  assign wr_last = ({1'b0, wr_idx} == n_wr - 3'd1);
  assign src_n   = w.src + (w.ctrl[SINC_BIT] ? (32'd1 << swc) : 32'd0);
  assign dst_n   = w.dst + (w.ctrl[DINC_BIT] ? (32'd1 << dwc) : 32'd0);
  assign cnt_n   = w.ctrl[CNT_W-1:0] - 1'b1;
  assign ctrl_n  = {w.ctrl[WORD_W-1:CNT_W], cnt_n};

  assign look_ch   = grant_ch;
  assign wb_en     = (state == ST_FIN);
  assign wb_ch     = w_ch;
  assign wb_val    = w;
  assign busy      = (state != ST_IDLE);
  assign pk_ld     = (state == ST_RD) && mem_ready && !mem_err;
  assign pk_ld_idx = rd_idx;
  assign pk_ld_wc  = swc;
  assign pk_pc_idx = (state == ST_WSET) ? 2'd0 : wr_idx + 2'd1;
  assign pk_pc_wc  = dwc;

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      w         <= '0;
      w_ch      <= '0;
      rd_idx    <= '0;
      wr_idx    <= '0;
      d_idx     <= '0;
      done      <= 1'b0;
      done_ch   <= '0;
      tc_evt    <= '0;
      err_evt   <= '0;
      mem_req   <= 1'b0;
      mem_we    <= 1'b0;
      mem_size  <= '0;
      mem_addr  <= '0;
      mem_wdata <= '0;
    end else begin
      done    <= 1'b0;
      tc_evt  <= '0;
      err_evt <= '0;
      case (state)
        ST_IDLE: begin
          if (grant_valid) begin
            w       <= look;
            w_ch    <= grant_ch;
            done_ch <= grant_ch;
            if (!look.conf[EN_BIT] || (look.ctrl[CNT_W-1:0] == '0)) begin
              done  <= 1'b1;
              state <= ST_FIN;
            end else begin
              mem_req  <= 1'b1;
              mem_we   <= 1'b0;
              mem_addr <= look.src;
              mem_size <= width_code(look.ctrl[SWC_LSB +: 3]);
              rd_idx   <= '0;
              state    <= ST_RD;
            end
          end
        end
        ST_RD: begin
          if (mem_ready) begin
            if (mem_err) begin
              mem_req          <= 1'b0;
              w.conf[EN_BIT]   <= 1'b0;
              err_evt[w_ch]    <= 1'b1;
              done             <= 1'b1;
              state            <= ST_FIN;
            end else begin
              w.src <= src_n;
              if (rd_last) begin
                mem_req <= 1'b0;
                state   <= ST_WSET;
              end else begin
                rd_idx   <= rd_idx + 2'd1;
                mem_addr <= src_n;
              end
            end
          end
        end
        ST_WSET: begin
          mem_req   <= 1'b1;
          mem_we    <= 1'b1;
          mem_addr  <= w.dst;
          mem_size  <= dwc;
          mem_wdata <= piece;
          wr_idx    <= '0;
          state     <= ST_WR;
        end
        ST_WR: begin
          if (mem_ready) begin
            if (mem_err) begin
              mem_req        <= 1'b0;
              w.conf[EN_BIT] <= 1'b0;
              err_evt[w_ch]  <= 1'b1;
              done           <= 1'b1;
              state          <= ST_FIN;
            end else begin
              w.dst <= dst_n;
              if (wr_last) begin
                mem_req <= 1'b0;
                w.ctrl  <= ctrl_n;
                if (cnt_n == '0 && w.ptr != '0) begin
                  mem_req  <= 1'b1;
                  mem_we   <= 1'b0;
                  mem_size <= 2'd2;
                  mem_addr <= w.ptr + desc_off(2'd0);
                  d_idx    <= '0;
                  state    <= ST_DESC;
                end else begin
                  if (cnt_n == '0) begin
                    w.conf[EN_BIT] <= 1'b0;
                    tc_evt[w_ch]   <= w.ctrl[TCIE_BIT];
                  end
                  done  <= 1'b1;
                  state <= ST_FIN;
                end
              end else begin
                wr_idx    <= wr_idx + 2'd1;
                mem_addr  <= dst_n;
                mem_wdata <= piece;
              end
            end
          end
        end
        ST_DESC: begin
          if (mem_ready) begin
            if (mem_err) begin
              mem_req        <= 1'b0;
              w.conf[EN_BIT] <= 1'b0;
              err_evt[w_ch]  <= 1'b1;
              done           <= 1'b1;
              state          <= ST_FIN;
            end else begin
              case (d_idx)
                2'd0: w.src  <= mem_rdata;
                2'd1: w.dst  <= mem_rdata;
                2'd2: w.ctrl <= mem_rdata;
                default: w.ptr <= mem_rdata;
              endcase
              if (d_idx == 2'd3) begin
                mem_req      <= 1'b0;
                tc_evt[w_ch] <= w.ctrl[TCIE_BIT];
                done         <= 1'b1;
                state        <= ST_FIN;
              end else begin
                d_idx    <= d_idx + 2'd1;
                mem_addr <= w.ptr + desc_off(d_idx + 2'd1);
              end
            end
          end
        end
        ST_FIN:  state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/lli_xfer_engine.sv
module lli_xfer_engine
  import lli_pkg::*;
#(
  parameter int NCH = 8,
  localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [CHW-1:0]    cfg_ch,
  input  logic [2:0]        cfg_sel,
  input  logic [WORD_W-1:0] cfg_wdata,
  input  logic              rd_en,
  input  logic [CHW-1:0]    rd_ch,
  input  logic [2:0]        rd_sel,
  output logic [WORD_W-1:0] rd_data,
  input  logic              grant_valid,
  input  logic [CHW-1:0]    grant_ch,
  output logic              busy,
  output logic              done,
  output logic [CHW-1:0]    done_ch,
  output logic [NCH-1:0]    tc_evt,
  output logic [NCH-1:0]    err_evt,
  output logic [NCH-1:0]    ch_en,
  output logic              mem_req,
  output logic              mem_we,
  output logic [1:0]        mem_size,
  output logic [WORD_W-1:0] mem_addr,
  output logic [WORD_W-1:0] mem_wdata,
  input  logic              mem_ready,
  input  logic              mem_err,
  input  logic [WORD_W-1:0] mem_rdata
);
  logic [CHW-1:0]    look_ch;
  chan_regs_t        look;
  logic              wb_en;
  logic [CHW-1:0]    wb_ch;
  chan_regs_t        wb_val;
  logic              pk_ld;
  logic [1:0]        pk_ld_idx, pk_ld_wc, pk_pc_idx, pk_pc_wc;
  logic [WORD_W-1:0] piece;

  lli_chan_regs #(.NCH(NCH)) u_regs (
    .clk(clk), .rst(rst),
    .cfg_we(cfg_we), .cfg_ch(cfg_ch), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .rd_en(rd_en), .rd_ch(rd_ch), .rd_sel(rd_sel), .rd_data(rd_data),
    .look_ch(look_ch), .look(look),
    .wb_en(wb_en), .wb_ch(wb_ch), .wb_val(wb_val),
    .ch_en(ch_en)
  );

  lli_pack u_pack (
    .clk(clk), .rst(rst),
    .ld(pk_ld), .ld_idx(pk_ld_idx), .ld_wc(pk_ld_wc), .ld_data(mem_rdata),
    .pc_idx(pk_pc_idx), .pc_wc(pk_pc_wc), .piece(piece)
  );

  lli_engine_fsm #(.NCH(NCH)) u_fsm (
    .clk(clk), .rst(rst),
    .grant_valid(grant_valid), .grant_ch(grant_ch),
    .look_ch(look_ch), .look(look),
    .wb_en(wb_en), .wb_ch(wb_ch), .wb_val(wb_val),
    .pk_ld(pk_ld), .pk_ld_idx(pk_ld_idx), .pk_ld_wc(pk_ld_wc),
    .pk_pc_idx(pk_pc_idx), .pk_pc_wc(pk_pc_wc), .piece(piece),
    .busy(busy), .done(done), .done_ch(done_ch),
    .tc_evt(tc_evt), .err_evt(err_evt),
    .mem_req(mem_req), .mem_we(mem_we), .mem_size(mem_size),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ready(mem_ready), .mem_err(mem_err), .mem_rdata(mem_rdata)
  );
endmodule

// File: rtl/lli_xfer_engine_chk.sv
module lli_xfer_engine_chk #(
  parameter int NCH = 8
) (
  input logic           clk,
  input logic           rst,
  input logic           cfg_we,
  input logic           busy,
  input logic           done,
  input logic           mem_req,
  input logic           mem_ready,
  input logic           mem_we,
  input logic [1:0]     mem_size,
  input logic [31:0]    mem_addr,
  input logic [31:0]    mem_wdata,
  input logic [NCH-1:0] tc_evt,
  input logic [NCH-1:0] err_evt,
  input logic [NCH-1:0] ch_en
);
  p_req_hold_r11: assert property (@(posedge clk) disable iff (rst)
    mem_req && !mem_ready |=> mem_req && $stable(mem_addr) && $stable(mem_we)
                              && $stable(mem_size) && $stable(mem_wdata));

  p_done_pulse_r11: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  p_idle_quiet_r11: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !mem_req && !done);

  p_tc_with_done_r9: assert property (@(posedge clk) disable iff (rst)
    (|tc_evt) |-> done && $onehot0(tc_evt));

  p_err_with_done_r10: assert property (@(posedge clk) disable iff (rst)
    (|err_evt) |-> done && $onehot0(err_evt));

  p_en_stable_r12: assert property (@(posedge clk) disable iff (rst)
    !cfg_we && !done |=> $stable(ch_en));

  for (genvar c = 0; c < NCH; c++) begin : g_err
    p_err_drops_en_r10: assert property (@(posedge clk) disable iff (rst)
      err_evt[c] && !cfg_we |=> !ch_en[c]);
  end
endmodule

bind lli_xfer_engine lli_xfer_engine_chk #(.NCH(NCH)) u_chk (
  .clk(clk), .rst(rst), .cfg_we(cfg_we), .busy(busy), .done(done),
  .mem_req(mem_req), .mem_ready(mem_ready), .mem_we(mem_we),
  .mem_size(mem_size), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
  .tc_evt(tc_evt), .err_evt(err_evt), .ch_en(ch_en)
);

// File: tb/lli_xfer_engine_test.sv
module lli_xfer_engine_test;
  localparam int NCH = 8;
  localparam int CHW = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg_we = 1'b0;
  logic [CHW-1:0] cfg_ch = '0;
  logic [2:0] cfg_sel = '0;
  logic [31:0] cfg_wdata = '0;
  logic rd_en = 1'b0;
  logic [CHW-1:0] rd_ch = '0;
  logic [2:0] rd_sel = '0;
  logic [31:0] rd_data;
  logic grant_valid = 1'b0;
  logic [CHW-1:0] grant_ch = '0;
  logic busy, done;
  logic [CHW-1:0] done_ch;
  logic [NCH-1:0] tc_evt, err_evt, ch_en;
  logic mem_req, mem_we;
  logic [1:0] mem_size;
  logic [31:0] mem_addr, mem_wdata;
  logic mem_ready = 1'b0;
  logic mem_err = 1'b0;
  logic [31:0] mem_rdata = '0;

  always #10 clk = ~clk;

  lli_xfer_engine #(.NCH(NCH)) uut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_ch(cfg_ch), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .rd_en(rd_en), .rd_ch(rd_ch), .rd_sel(rd_sel),
    .rd_data(rd_data), .grant_valid(grant_valid), .grant_ch(grant_ch),
    .busy(busy), .done(done), .done_ch(done_ch), .tc_evt(tc_evt),
    .err_evt(err_evt), .ch_en(ch_en), .mem_req(mem_req), .mem_we(mem_we),
    .mem_size(mem_size), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ready(mem_ready), .mem_err(mem_err), .mem_rdata(mem_rdata)
  );

  int tests = 0;
  int fails = 0;

  // memory model and transaction log
  logic [7:0]  mem [256];
  int          lat = 0;
  int          wcnt = 0;
  logic [31:0] err_addr = 32'hFFFF_FFFF;
  int          log_n = 0;
  logic        log_we   [32];
  logic [31:0] log_addr [32];
  logic [1:0]  log_size [32];
  logic [31:0] log_data [32];

  always @(negedge clk) begin
    if (rst) begin
      mem_ready = 1'b0;
      wcnt = 0;
    end else if (mem_ready) begin
      mem_ready = 1'b0;
      mem_err = 1'b0;
      wcnt = 0;
    end else if (mem_req) begin
      if (wcnt >= lat) begin
        logic [31:0] d;
        d = '0;
        for (int b = 0; b < (1 << mem_size); b++) begin
          if (mem_we) mem[8'(mem_addr + b)] = mem_wdata[8*b +: 8];
          else d[8*b +: 8] = mem[8'(mem_addr + b)];
        end
        mem_rdata = d;
        mem_err = (mem_addr == err_addr);
        mem_ready = 1'b1;
        if (log_n < 32) begin
          log_we[log_n] = mem_we;
          log_addr[log_n] = mem_addr;
          log_size[log_n] = mem_size;
          log_data[log_n] = mem_we ? mem_wdata : d;
        end
        log_n++;
      end else begin
        wcnt++;
      end
    end
  end

  // event monitor
  int done_cnt = 0;
  logic [NCH-1:0] tc_seen = '0;
  logic [NCH-1:0] err_seen = '0;
  logic [CHW-1:0] last_done_ch = '0;
  always @(negedge clk) begin
    if (!rst) begin
      if (done) begin
        done_cnt++;
        last_done_ch = done_ch;
      end
      tc_seen |= tc_evt;
      err_seen |= err_evt;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic clear_mon();
    done_cnt = 0;
    tc_seen = '0;
    err_seen = '0;
    log_n = 0;
  endtask

  task automatic cfg_write(input int ch, input int sel, input logic [31:0] v);
    @(negedge clk);
    cfg_we = 1'b1; cfg_ch = CHW'(ch); cfg_sel = 3'(sel); cfg_wdata = v;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic cfg_read(input int ch, input int sel, output logic [31:0] v);
    @(negedge clk);
    rd_en = 1'b1; rd_ch = CHW'(ch); rd_sel = 3'(sel);
    @(negedge clk);
    rd_en = 1'b0;
    v = rd_data;
  endtask

  task automatic set_chan(input int ch, input logic [31:0] s, input logic [31:0] d,
                          input logic [31:0] p, input logic [31:0] c, input logic [31:0] f);
    cfg_write(ch, 0, s);
    cfg_write(ch, 1, d);
    cfg_write(ch, 2, p);
    cfg_write(ch, 3, c);
    cfg_write(ch, 4, f);
  endtask

  task automatic put_word(input int a, input logic [31:0] v);
    for (int b = 0; b < 4; b++) mem[8'(a + b)] = v[8*b +: 8];
  endtask

  task automatic grant_and_wait(input int ch);
    int guard;
    @(negedge clk);
    grant_valid = 1'b1; grant_ch = CHW'(ch);
    @(negedge clk);
    grant_valid = 1'b0;
    guard = 0;
    while (done_cnt == 0 && guard < 2000) begin
      @(negedge clk);
      guard++;
    end
    repeat (3) @(negedge clk);
  endtask

  task automatic expect_txn(input string req, input int i, input logic we,
                            input logic [31:0] a, input logic [1:0] sz, input logic [31:0] d);
    check({req, " dir"}, 32'(log_we[i]), 32'(we));
    check({req, " addr"}, log_addr[i], a);
    check({req, " size"}, 32'(log_size[i]), 32'(sz));
    check({req, " data"}, log_data[i], d);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    check("R1 ch_en", 32'(ch_en), 32'h0);
    check("R1 mem_req", 32'(mem_req), 32'h0);
    check("R1 busy", 32'(busy), 32'h0);
    check("R1 done", 32'(done), 32'h0);
    cfg_read(0, 3, v);
    check("R1 ctrl zero", v, 32'h0);
  endtask

  task automatic t_regs();
    logic [31:0] v;
    cfg_write(3, 0, 32'h1234_5678);
    cfg_read(3, 0, v);
    check("R2 src readback", v, 32'h1234_5678);
    cfg_read(3, 2, v);
    check("R2 ptr untouched", v, 32'h0);
    cfg_write(3, 4, 32'h0000_0001);
    check("R2 en bit", 32'(ch_en[3]), 32'h1);
    cfg_write(3, 4, 32'h0);
  endtask

  task automatic t_skip();
    logic [31:0] v;
    set_chan(1, 32'h10, 32'h80, 32'h0, 32'h0C48_0000, 32'h1);
    clear_mon();
    grant_and_wait(1);
    check("R3 zero count done", 32'(done_cnt), 32'd1);
    check("R3 zero count no mem", 32'(log_n), 32'd0);
    cfg_read(1, 3, v);
    check("R3 ctrl unchanged", v, 32'h0C48_0000);
    set_chan(7, 32'h10, 32'h80, 32'h0, 32'h0C48_0003, 32'h0);
    clear_mon();
    grant_and_wait(7);
    check("R3 disabled done", 32'(done_cnt), 32'd1);
    check("R3 disabled done_ch", 32'(last_done_ch), 32'd7);
    check("R3 disabled no mem", 32'(log_n), 32'd0);
    cfg_read(7, 3, v);
    check("R3 disabled ctrl", v, 32'h0C48_0003);
  endtask

  task automatic t_word_copy();
    logic [31:0] v;
    put_word(32'h10, 32'h4433_2211);
    put_word(32'h14, 32'h8877_6655);
    set_chan(0, 32'h10, 32'h80, 32'h0, 32'h8C48_0002, 32'h0000_00C1);
    clear_mon();
    grant_and_wait(0);
    check("R4 word count", 32'(log_n), 32'd2);
    expect_txn("R4 word rd", 0, 1'b0, 32'h10, 2'd2, 32'h4433_2211);
    expect_txn("R4 word wr", 1, 1'b1, 32'h80, 2'd2, 32'h4433_2211);
    cfg_read(0, 3, v);
    check("R6 count down", v, 32'h8C48_0001);
    cfg_read(0, 0, v);
    check("R5 src inc", v, 32'h14);
    cfg_read(0, 1, v);
    check("R5 dst inc", v, 32'h84);
    check("R9 no tc midway", 32'(tc_seen), 32'h0);
    check("R12 en kept", 32'(ch_en[0]), 32'h1);
    clear_mon();
    grant_and_wait(0);
    cfg_read(0, 3, v);
    check("R6 count zero", v, 32'h8C48_0000);
    cfg_read(0, 4, v);
    check("R7 conf en cleared", v, 32'h0000_00C0);
    check("R7 ch_en low", 32'(ch_en[0]), 32'h0);
    check("R9 tc event", 32'(tc_seen), 32'h01);
    check("R11 one done", 32'(done_cnt), 32'd1);
  endtask

  task automatic t_widths();
    logic [31:0] v;
    put_word(32'h20, 32'hD4C3_B2A1);
    set_chan(4, 32'h20, 32'hA0, 32'h0, 32'h0C40_0001, 32'h1);
    clear_mon();
    grant_and_wait(4);
    check("R4 byte->word count", 32'(log_n), 32'd5);
    for (int i = 0; i < 4; i++)
      expect_txn("R4 byte rd", i, 1'b0, 32'h20 + i, 2'd0, 32'(mem[8'(32'h20 + i)]));
    expect_txn("R4 packed wr", 4, 1'b1, 32'hA0, 2'd2, 32'hD4C3_B2A1);
    cfg_read(4, 0, v);
    check("R5 src by byte", v, 32'h24);
    check("R9 no tc bit31 clear", 32'(tc_seen), 32'h0);
    check("R7 disabled at end", 32'(ch_en[4]), 32'h0);
    put_word(32'h30, 32'h5566_7788);
    set_chan(5, 32'h30, 32'hB0, 32'h0, 32'h043C_0001, 32'h1);
    clear_mon();
    grant_and_wait(5);
    check("R4 word->half count", 32'(log_n), 32'd3);
    expect_txn("R4 clamped rd", 0, 1'b0, 32'h30, 2'd2, 32'h5566_7788);
    expect_txn("R4 half wr0", 1, 1'b1, 32'hB0, 2'd1, 32'h0000_7788);
    expect_txn("R5 half wr1 fixed", 2, 1'b1, 32'hB0, 2'd1, 32'h0000_5566);
    cfg_read(5, 1, v);
    check("R5 dst fixed", v, 32'hB0);
  endtask

  task automatic t_chain();
    logic [31:0] v;
    put_word(32'h50, 32'hCAFE_F00D);
    put_word(32'h40, 32'h58);
    put_word(32'h44, 32'hC8);
    put_word(32'h48, 32'h0);
    put_word(32'h4C, 32'h8C48_0003);
    set_chan(2, 32'h50, 32'hC0, 32'h40, 32'h0C48_0001, 32'h1);
    clear_mon();
    grant_and_wait(2);
    check("R8 txn count", 32'(log_n), 32'd6);
    expect_txn("R8 elem wr", 1, 1'b1, 32'hC0, 2'd2, 32'hCAFE_F00D);
    expect_txn("R8 fetch +0", 2, 1'b0, 32'h40, 2'd2, 32'h58);
    expect_txn("R8 fetch +4", 3, 1'b0, 32'h44, 2'd2, 32'hC8);
    expect_txn("R8 fetch +12", 4, 1'b0, 32'h4C, 2'd2, 32'h8C48_0003);
    expect_txn("R8 fetch +8", 5, 1'b0, 32'h48, 2'd2, 32'h0);
    cfg_read(2, 0, v);
    check("R8 src reloaded", v, 32'h58);
    cfg_read(2, 1, v);
    check("R8 dst reloaded", v, 32'hC8);
    cfg_read(2, 3, v);
    check("R8 ctrl reloaded", v, 32'h8C48_0003);
    cfg_read(2, 2, v);
    check("R8 ptr reloaded", v, 32'h0);
    check("R8 still enabled", 32'(ch_en[2]), 32'h1);
    check("R9 tc from reloaded ctrl", 32'(tc_seen), 32'h04);
    check("R11 one done", 32'(done_cnt), 32'd1);
  endtask

  task automatic t_error();
    logic [31:0] v;
    err_addr = 32'hF0;
    set_chan(6, 32'hF0, 32'hD0, 32'h0, 32'h0C48_0005, 32'h1);
    clear_mon();
    grant_and_wait(6);
    check("R10 err event", 32'(err_seen), 32'h40);
    check("R10 en cleared", 32'(ch_en[6]), 32'h0);
    check("R10 no write", 32'(log_n), 32'd1);
    cfg_read(6, 3, v);
    check("R10 count kept", v, 32'h0C48_0005);
    check("R10 done", 32'(done_cnt), 32'd1);
    err_addr = 32'hFFFF_FFFF;
  endtask

  task automatic t_busy_grant();
    logic [31:0] v;
    int guard;
    lat = 3;
    put_word(32'h60, 32'h0BAD_BEEF);
    set_chan(3, 32'h60, 32'hE0, 32'h0, 32'h0C48_0002, 32'h1);
    clear_mon();
    @(negedge clk);
    grant_valid = 1'b1; grant_ch = 3'd3;
    @(negedge clk);
    grant_valid = 1'b0;
    @(negedge clk);
    check("R11 busy", 32'(busy), 32'h1);
    grant_valid = 1'b1; grant_ch = 3'd3;
    @(negedge clk);
    grant_valid = 1'b0;
    guard = 0;
    while (done_cnt == 0 && guard < 2000) begin
      @(negedge clk);
      guard++;
    end
    repeat (10) @(negedge clk);
    check("R11 single done", 32'(done_cnt), 32'd1);
    check("R11 one element", 32'(log_n), 32'd2);
    cfg_read(3, 3, v);
    check("R11 count once", v, 32'h0C48_0001);
    check("R12 en unchanged", 32'(ch_en[3]), 32'h1);
    lat = 0;
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 8'(i);
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_regs();
    t_skip();
    t_word_copy();
    t_widths();
    t_chain();
    t_error();
    t_busy_grant();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    tests++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule